// File: doc/BRIEF.md
# Instruction-Cache Tag Lookup with Parity Checking

This block looks up a physical address in a set-associative instruction-cache tag array and returns a hit way or an error code in the same cycle. Each tag entry stores two copies of its valid bit, the tag and an even-parity bit over the tag. Each line holds a group of instruction words, and each word carries an even-parity bit. The lookup runs a fixed, ordered set of checks. An error-enable vector gates each check, and the highest-priority enabled failure is the one reported.

Any reported error is recovered on the next clock edge: both valid copies of every way in the indexed set are cleared, and the words of that set are discarded. A miss with no error picks a victim way from a global round-robin pointer and installs the tag with good parity and both valid copies set. A flush request clears the hitting way without running any checks. Two diagnostic write ports let software seed tag entries and instruction words. They can also deliberately corrupt tag parity, the valid copies or word parity, which is how the error paths are exercised.

Top module: `icl_tag_lookup`

## Requirements
- R1: After reset every way of every set is invalid, so a lookup reports a miss with error code 0, and the fill pointer `fill_way_o` is 0.
- R2: A lookup with no enabled error that matches no valid way asserts `miss_o` and, on the next edge, installs the tag into way `fill_way_o` of the indexed set; a later lookup of that address asserts `hit_o` with `hit_way_o` equal to that way.
- R3: The fill pointer advances by one on each miss, wrapping from WAYS-1 to 0, and holds otherwise.
- R4: When enable bit 0 is set and any way of the set has unequal valid copies, error code 1 is reported for the lowest such way.
- R5: When enable bit 1 is set, a way with either valid copy set whose stored parity differs from the even parity of its tag yields error code 2 for the lowest such way.
- R6: When two or more valid ways match the tag, enable bit 2 set yields error code 3 naming the second-lowest matching way; with bit 2 clear the lookup hits the lowest matching way.
- R7: When enable bit 3 is set and the addressed word (address bits 4:2) of the hit way fails even parity, error code 4 is reported for the hit way.
- R8: Codes are ranked 1 over 2 over 3 over 4; only the highest-ranked enabled failure is reported, and a reported error suppresses both `hit_o` and `miss_o`.
- R9: With a nonzero error code, `err_addr_o` equals the reported way shifted left by 6, ORed with the set index.
- R10: On the edge after an error, every way of the indexed set becomes invalid; other sets are unchanged.
- R11: A diagnostic tag write stores parity equal to the tag's even parity XOR the parity-flip bit, sets valid copy 1 from the input and sets valid copy 0 to valid copy 1 XOR the valid-flip bit; a diagnostic word write stores the word's even parity XOR its flip bit.
- R12: A flush (`req_i` and `flush_i` both high) clears both valid copies of the lowest matching way, reports error code 0, and neither asserts `miss_o` nor moves the fill pointer.
- R13: A check whose enable bit is clear has no effect: the lookup reports the hit or miss that would result without it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Address request valid |
| flush_i | input | 1 | Request is a flush, not a lookup |
| addr_i | input | PA_W | Physical address: tag, set index, word, byte offset |
| chk_en_i | input | 4 | Check enables: 0 valid copies, 1 tag parity, 2 multi-match, 3 word parity |
| hit_o | output | 1 | Error-free hit |
| hit_way_o | output | WAY_W | Lowest matching way |
| miss_o | output | 1 | Error-free miss; fill happens on next edge |
| fill_way_o | output | WAY_W | Round-robin victim way |
| err_code_o | output | 3 | 0 none, 1 valid mismatch, 2 tag parity, 3 multi-match, 4 word parity |
| err_addr_o | output | WAY_W+6 | Error way shifted left by 6, ORed with set index |
| tw_we_i | input | 1 | Diagnostic tag write |
| tw_set_i | input | IDX_W | Diagnostic tag set |
| tw_way_i | input | WAY_W | Diagnostic tag way |
| tw_tag_i | input | TAG_W | Diagnostic tag value |
| tw_vld_i | input | 1 | Valid copy 1 value |
| tw_par_flip_i | input | 1 | Invert stored tag parity |
| tw_vld_flip_i | input | 1 | Make valid copy 0 differ from copy 1 |
| ww_we_i | input | 1 | Diagnostic word write |
| ww_set_i | input | IDX_W | Diagnostic word set |
| ww_way_i | input | WAY_W | Diagnostic word way |
| ww_word_i | input | WORD_W | Diagnostic word slot |
| ww_data_i | input | INSTR_W | Instruction word |
| ww_par_flip_i | input | 1 | Invert stored word parity |

## Verification
The assertions take for granted that at most one of lookup, flush, diagnostic tag write and diagnostic word write is active in a cycle. They also take for granted that every input is at a known value whenever reset is released. The stimulus meets this by running each operation in its own task, which raises one request for exactly one clock edge and drops it before the next task starts. Lookups that hit on purpose use addresses installed earlier by a miss or by a diagnostic write. The bench therefore tracks the fill pointer from the sequence of misses alone.

// File: rtl/icl_pkg.sv
package icl_pkg;
  typedef enum logic [2:0] {
    ERR_NONE  = 3'd0,
    ERR_VALID = 3'd1,
    ERR_TPAR  = 3'd2,
    ERR_MULTI = 3'd3,
    ERR_IPAR  = 3'd4
  } err_code_e;

  localparam int EN_VALID = 0;
  localparam int EN_TPAR  = 1;
  localparam int EN_MULTI = 2;
  localparam int EN_IPAR  = 3;
  localparam int ERR_ADDR_SHIFT = 6;
  localparam int BYTE_OFF_W = 2;
endpackage

// File: rtl/icl_tag_array.sv
module icl_tag_array #(
  parameter int WAYS  = 8,
  parameter int SETS  = 16,
  parameter int TAG_W = 12,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int ENT_W = TAG_W + 3
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [IDX_W-1:0]             rd_set_i,
  output logic [WAYS-1:0][ENT_W-1:0]   rd_ent_o,
  input  logic                         inval_en_i,
  input  logic [IDX_W-1:0]             inval_set_i,
  input  logic                         fill_en_i,
  input  logic [IDX_W-1:0]             fill_set_i,
  input  logic [WAY_W-1:0]             fill_way_i,
  input  logic [TAG_W-1:0]             fill_tag_i,
  input  logic                         flush_en_i,
  input  logic [IDX_W-1:0]             flush_set_i,
  input  logic [WAY_W-1:0]             flush_way_i,
  input  logic                         dw_en_i,
  input  logic [IDX_W-1:0]             dw_set_i,
  input  logic [WAY_W-1:0]             dw_way_i,
  input  logic [TAG_W-1:0]             dw_tag_i,
  input  logic                         dw_vld_i,
  input  logic                         dw_par_flip_i,
  input  logic                         dw_vld_flip_i
);
  // entry layout: {valid1, valid0, parity, tag}
  localparam int PAR_B = TAG_W;
  localparam int V0_B  = TAG_W + 1;
  localparam int V1_B  = TAG_W + 2;

  logic [ENT_W-1:0] mem_q [SETS][WAYS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          mem_q[s][w] <= '0;
    end else if (inval_en_i) begin
      for (int w = 0; w < WAYS; w++) begin
        mem_q[inval_set_i][w][V0_B] <= 1'b0;
        mem_q[inval_set_i][w][V1_B] <= 1'b0;
      end
    end else if (fill_en_i) begin
      mem_q[fill_set_i][fill_way_i] <= {1'b1, 1'b1, ^fill_tag_i, fill_tag_i};
    end else if (flush_en_i) begin
      mem_q[flush_set_i][flush_way_i][V0_B] <= 1'b0;
      mem_q[flush_set_i][flush_way_i][V1_B] <= 1'b0;
    end else if (dw_en_i) begin
      mem_q[dw_set_i][dw_way_i] <= {dw_vld_i, dw_vld_i ^ dw_vld_flip_i,
                                    (^dw_tag_i) ^ dw_par_flip_i, dw_tag_i};
    end
  end

  always_comb begin
    for (int w = 0; w < WAYS; w++)
      rd_ent_o[w] = mem_q[rd_set_i][w];
  end

  function automatic logic set_has_valid(input logic [IDX_W-1:0] s);
    logic any;
    any = 1'b0;
    for (int w = 0; w < WAYS; w++)
      any = any | mem_q[s][w][V0_B] | mem_q[s][w][V1_B];
    return any;
  endfunction

  assert_set_cleared_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inval_en_i |=> !set_has_valid($past(inval_set_i)));

  assert_diag_parity_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dw_en_i && !inval_en_i && !fill_en_i && !flush_en_i) |=>
      (mem_q[$past(dw_set_i)][$past(dw_way_i)][PAR_B] ==
       ((^$past(dw_tag_i)) ^ $past(dw_par_flip_i))));

  assert_diag_valid_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dw_en_i && !inval_en_i && !fill_en_i && !flush_en_i) |=>
      ((mem_q[$past(dw_set_i)][$past(dw_way_i)][V1_B] ^
        mem_q[$past(dw_set_i)][$past(dw_way_i)][V0_B]) == $past(dw_vld_flip_i)));
endmodule

// File: rtl/icl_word_array.sv
module icl_word_array #(
  parameter int WAYS    = 8,
  parameter int SETS    = 16,
  parameter int WORDS   = 8,
  parameter int INSTR_W = 32,
  localparam int IDX_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int WORD_W = $clog2(WORDS),
  localparam int CELL_W = INSTR_W + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [IDX_W-1:0]     rd_set_i,
  input  logic [WORD_W-1:0]    rd_word_i,
  output logic [WAYS-1:0]      rd_par_err_o,
  input  logic                 inval_en_i,
  input  logic [IDX_W-1:0]     inval_set_i,
  input  logic                 fill_en_i,
  input  logic [IDX_W-1:0]     fill_set_i,
  input  logic [WAY_W-1:0]     fill_way_i,
  input  logic                 dw_en_i,
  input  logic [IDX_W-1:0]     dw_set_i,
  input  logic [WAY_W-1:0]     dw_way_i,
  input  logic [WORD_W-1:0]    dw_word_i,
  input  logic [INSTR_W-1:0]   dw_data_i,
  input  logic                 dw_par_flip_i
);
  // cell layout: {parity, instruction}; all-zero is a clean word
  logic [CELL_W-1:0] mem_q [SETS][WAYS][WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          for (int k = 0; k < WORDS; k++)
            mem_q[s][w][k] <= '0;
    end else if (inval_en_i) begin
      for (int w = 0; w < WAYS; w++)
        for (int k = 0; k < WORDS; k++)
          mem_q[inval_set_i][w][k] <= '0;
    end else if (fill_en_i) begin
      for (int k = 0; k < WORDS; k++)
        mem_q[fill_set_i][fill_way_i][k] <= '0;
    end else if (dw_en_i) begin
      mem_q[dw_set_i][dw_way_i][dw_word_i] <= {(^dw_data_i) ^ dw_par_flip_i, dw_data_i};
    end
  end

  always_comb begin
    for (int w = 0; w < WAYS; w++)
      rd_par_err_o[w] = ^mem_q[rd_set_i][w][rd_word_i];
  end
endmodule

// File: rtl/icl_check.sv
module icl_check
  import icl_pkg::*;
#(
  parameter int WAYS  = 8,
  parameter int TAG_W = 12,
  localparam int WAY_W = $clog2(WAYS),
  localparam int ENT_W = TAG_W + 3
) (
  input  logic [WAYS-1:0][ENT_W-1:0] ent_i,
  input  logic [TAG_W-1:0]           tag_i,
  input  logic [2:0]                 en_i,
  output logic [WAYS-1:0]            match_o,
  output logic                       any_hit_o,
  output logic [WAY_W-1:0]           hit_way_o,
  output err_code_e                  code_o,
  output logic [WAY_W-1:0]           err_way_o
);
  logic [WAYS-1:0] vmis, vany, perr, match_rest;

  function automatic logic [WAY_W-1:0] first_idx(input logic [WAYS-1:0] v);
    logic [WAY_W-1:0] r;
    r = '0;
    for (int i = WAYS - 1; i >= 0; i--)
      if (v[i]) r = WAY_W'(i);
    return r;
  endfunction

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      vmis[w]    = ent_i[w][TAG_W+2] ^ ent_i[w][TAG_W+1];
      vany[w]    = ent_i[w][TAG_W+2] | ent_i[w][TAG_W+1];
      perr[w]    = vany[w] & ((^ent_i[w][TAG_W-1:0]) ^ ent_i[w][TAG_W]);
      match_o[w] = vany[w] & (ent_i[w][TAG_W-1:0] == tag_i);
    end
  end

  // clear the lowest matching bit: any remainder means a second match
  assign match_rest = match_o & (match_o - WAYS'(1));
  assign any_hit_o  = |match_o;
  assign hit_way_o  = first_idx(match_o);

  always_comb begin
    code_o    = ERR_NONE;
    err_way_o = '0;
    if (en_i[EN_VALID] && |vmis) begin
      code_o    = ERR_VALID;
      err_way_o = first_idx(vmis);
    end else if (en_i[EN_TPAR] && |perr) begin
      code_o    = ERR_TPAR;
      err_way_o = first_idx(perr);
    end else if (en_i[EN_MULTI] && |match_rest) begin
      code_o    = ERR_MULTI;
      err_way_o = first_idx(match_rest);
    end
  end
endmodule

// File: rtl/icl_tag_lookup.sv
module icl_tag_lookup
  import icl_pkg::*;
#(
  parameter int WAYS    = 8,
  parameter int SETS    = 16,
  parameter int WORDS   = 8,
  parameter int TAG_W   = 12,
  parameter int INSTR_W = 32,
  localparam int IDX_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int WORD_W = $clog2(WORDS),
  localparam int OFF_W  = BYTE_OFF_W + WORD_W,
  localparam int PA_W   = TAG_W + IDX_W + OFF_W,
  localparam int EA_W   = WAY_W + ERR_ADDR_SHIFT,
  localparam int ENT_W  = TAG_W + 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               flush_i,
  input  logic [PA_W-1:0]    addr_i,
  input  logic [3:0]         chk_en_i,
  output logic               hit_o,
  output logic [WAY_W-1:0]   hit_way_o,
  output logic               miss_o,
  output logic [WAY_W-1:0]   fill_way_o,
  output logic [2:0]         err_code_o,
  output logic [EA_W-1:0]    err_addr_o,
  input  logic               tw_we_i,
  input  logic [IDX_W-1:0]   tw_set_i,
  input  logic [WAY_W-1:0]   tw_way_i,
  input  logic [TAG_W-1:0]   tw_tag_i,
  input  logic               tw_vld_i,
  input  logic               tw_par_flip_i,
  input  logic               tw_vld_flip_i,
  input  logic               ww_we_i,
  input  logic [IDX_W-1:0]   ww_set_i,
  input  logic [WAY_W-1:0]   ww_way_i,
  input  logic [WORD_W-1:0]  ww_word_i,
  input  logic [INSTR_W-1:0] ww_data_i,
  input  logic               ww_par_flip_i
);
  logic [TAG_W-1:0]  a_tag;
  logic [IDX_W-1:0]  a_idx;
  logic [WORD_W-1:0] a_word;
  assign a_tag  = addr_i[PA_W-1 -: TAG_W];
  assign a_idx  = addr_i[OFF_W +: IDX_W];
  assign a_word = addr_i[BYTE_OFF_W +: WORD_W];

  logic                       lkp, flush;
  logic [WAYS-1:0][ENT_W-1:0] ent;
  logic [WAYS-1:0]            word_perr;
  logic [WAYS-1:0]            match;
  logic                       any_hit;
  logic [WAY_W-1:0]           lo_way, tag_err_way, err_way;
  err_code_e                  tag_code, code;
  logic                       err, miss;
  logic [WAY_W-1:0]           rr_q;

  assign lkp   = req_i & ~flush_i;
  assign flush = req_i &  flush_i;

  icl_check #(.WAYS(WAYS), .TAG_W(TAG_W)) u_check (
    .ent_i     (ent),
    .tag_i     (a_tag),
    .en_i      (chk_en_i[2:0]),
    .match_o   (match),
    .any_hit_o (any_hit),
    .hit_way_o (lo_way),
    .code_o    (tag_code),
    .err_way_o (tag_err_way)
  );

  always_comb begin
    code    = ERR_NONE;
    err_way = '0;
    if (lkp) begin
      if (tag_code != ERR_NONE) begin
        code    = tag_code;
        err_way = tag_err_way;
      end else if (any_hit && chk_en_i[EN_IPAR] && word_perr[lo_way]) begin
        code    = ERR_IPAR;
        err_way = lo_way;
      end
    end
  end

  assign err  = lkp & (code != ERR_NONE);
  assign miss = lkp & (code == ERR_NONE) & ~any_hit;

  assign hit_o      = lkp & (code == ERR_NONE) & any_hit;
  assign hit_way_o  = lo_way;
  assign miss_o     = miss;
  assign fill_way_o = rr_q;
  assign err_code_o = code;
  assign err_addr_o = err ? ((EA_W'(err_way) << ERR_ADDR_SHIFT) | EA_W'(a_idx)) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rr_q <= '0;
    else if (miss)    rr_q <= (rr_q == WAY_W'(WAYS - 1)) ? '0 : rr_q + WAY_W'(1);
  end

  icl_tag_array #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .rd_set_i      (a_idx),
    .rd_ent_o      (ent),
    .inval_en_i    (err),
    .inval_set_i   (a_idx),
    .fill_en_i     (miss),
    .fill_set_i    (a_idx),
    .fill_way_i    (rr_q),
    .fill_tag_i    (a_tag),
    .flush_en_i    (flush & any_hit),
    .flush_set_i   (a_idx),
    .flush_way_i   (lo_way),
    .dw_en_i       (tw_we_i),
    .dw_set_i      (tw_set_i),
    .dw_way_i      (tw_way_i),
    .dw_tag_i      (tw_tag_i),
    .dw_vld_i      (tw_vld_i),
    .dw_par_flip_i (tw_par_flip_i),
    .dw_vld_flip_i (tw_vld_flip_i)
  );

  icl_word_array #(.WAYS(WAYS), .SETS(SETS), .WORDS(WORDS), .INSTR_W(INSTR_W)) u_words (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .rd_set_i      (a_idx),
    .rd_word_i     (a_word),
    .rd_par_err_o  (word_perr),
    .inval_en_i    (err),
    .inval_set_i   (a_idx),
    .fill_en_i     (miss),
    .fill_set_i    (a_idx),
    .fill_way_i    (rr_q),
    .dw_en_i       (ww_we_i),
    .dw_set_i      (ww_set_i),
    .dw_way_i      (ww_way_i),
    .dw_word_i     (ww_word_i),
    .dw_data_i     (ww_data_i),
    .dw_par_flip_i (ww_par_flip_i)
  );

  function automatic logic [WAY_W-1:0] rr_next(input logic [WAY_W-1:0] v);
    return (v == WAY_W'(WAYS - 1)) ? '0 : v + WAY_W'(1);
  endfunction

  assert_fill_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |=> fill_way_o == rr_next($past(fill_way_o)));

  assert_fill_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !miss_o |=> $stable(fill_way_o));

  assert_flush_no_fill_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && flush_i) |=> $stable(fill_way_o));

  assert_err_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_code_o != 3'd0) |-> (!hit_o && !miss_o));

  assert_multi_two_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_code_o == 3'd3) |-> ($countones(match) >= 2));

  assert_ipar_hit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_code_o == 3'd4) |-> (chk_en_i[EN_IPAR] && any_hit && word_perr[lo_way]));

  assert_miss_nomatch_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |-> (match == '0));
endmodule

// File: tb/icl_tag_lookup_bench.sv
module icl_tag_lookup_bench;
  localparam int WAYS = 8, SETS = 16, WORDS = 8, TAG_W = 12, INSTR_W = 32;
  localparam int IDX_W = 4, WAY_W = 3, WORD_W = 3;
  localparam int PA_W = TAG_W + IDX_W + WORD_W + 2;
  localparam int EA_W = WAY_W + 6;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk_i = ~clk_i;

  logic               req_i = 0, flush_i = 0;
  logic [PA_W-1:0]    addr_i = '0;
  logic [3:0]         chk_en_i = '0;
  logic               hit_o, miss_o;
  logic [WAY_W-1:0]   hit_way_o, fill_way_o;
  logic [2:0]         err_code_o;
  logic [EA_W-1:0]    err_addr_o;
  logic               tw_we_i = 0, tw_vld_i = 0, tw_par_flip_i = 0, tw_vld_flip_i = 0;
  logic [IDX_W-1:0]   tw_set_i = '0;
  logic [WAY_W-1:0]   tw_way_i = '0;
  logic [TAG_W-1:0]   tw_tag_i = '0;
  logic               ww_we_i = 0, ww_par_flip_i = 0;
  logic [IDX_W-1:0]   ww_set_i = '0;
  logic [WAY_W-1:0]   ww_way_i = '0;
  logic [WORD_W-1:0]  ww_word_i = '0;
  logic [INSTR_W-1:0] ww_data_i = '0;

  icl_tag_lookup u_icl_tag_lookup (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  int g_hit, g_way, g_miss, g_fill, g_code, g_eaddr;

  task automatic check(input string req, input string what, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  function automatic logic [PA_W-1:0] mk(input int tag, input int set, input int word);
    return {TAG_W'(tag), IDX_W'(set), WORD_W'(word), 2'b00};
  endfunction

  task automatic access(input int tag, input int set, input int word, input logic [3:0] en,
                        input logic fl);
    @(negedge clk_i);
    req_i = 1; flush_i = fl; addr_i = mk(tag, set, word); chk_en_i = en;
    #2;
    g_hit = int'(hit_o); g_way = int'(hit_way_o); g_miss = int'(miss_o);
    g_fill = int'(fill_way_o); g_code = int'(err_code_o); g_eaddr = int'(err_addr_o);
    @(negedge clk_i);
    req_i = 0; flush_i = 0;
  endtask

  task automatic tag_wr(input int set, input int way, input int tag, input logic pflip,
                        input logic vflip);
    @(negedge clk_i);
    tw_we_i = 1; tw_set_i = IDX_W'(set); tw_way_i = WAY_W'(way); tw_tag_i = TAG_W'(tag);
    tw_vld_i = 1; tw_par_flip_i = pflip; tw_vld_flip_i = vflip;
    @(negedge clk_i);
    tw_we_i = 0;
  endtask

  task automatic word_wr(input int set, input int way, input int word, input int data,
                         input logic pflip);
    @(negedge clk_i);
    ww_we_i = 1; ww_set_i = IDX_W'(set); ww_way_i = WAY_W'(way); ww_word_i = WORD_W'(word);
    ww_data_i = INSTR_W'(data); ww_par_flip_i = pflip;
    @(negedge clk_i);
    ww_we_i = 0;
  endtask

  task automatic expect_hit(input string req, input int way);
    check(req, "hit", g_hit, 1);
    check(req, "hit_way", g_way, way);
    check(req, "code", g_code, 0);
  endtask

  task automatic expect_miss(input string req, input int fill);
    check(req, "miss", g_miss, 1);
    check(req, "hit", g_hit, 0);
    check(req, "code", g_code, 0);
    check(req, "fill_way", g_fill, fill);
  endtask

  task automatic expect_err(input string req, input int code, input int way, input int set);
    check(req, "code", g_code, code);
    check(req, "err_addr", g_eaddr, (way << 6) | set);
    check(req, "no hit/miss", g_hit | g_miss, 0);
  endtask

  // R1
  task automatic t_reset();
    #1;
    check("R1", "idle hit", int'(hit_o), 0);
    check("R1", "idle code", int'(err_code_o), 0);
    check("R1", "fill ptr", int'(fill_way_o), 0);
    access(5, 3, 0, 4'hF, 0);
    expect_miss("R1", 0);
  endtask

  // R2, R3
  task automatic t_fill_rr();
    access(5, 3, 0, 4'hF, 0);
    expect_hit("R2", 0);
    access(6, 3, 0, 4'hF, 0);
    expect_miss("R3", 1);
    for (int i = 0; i < 6; i++) begin
      access(20 + i, 5, 0, 4'hF, 0);
      expect_miss("R3", 2 + i);
    end
    access(26, 5, 0, 4'hF, 0);
    expect_miss("R3", 0);
    access(25, 5, 0, 4'hF, 0);
    expect_hit("R2", 7);
  endtask

  // R7, R13, R10
  task automatic t_word_parity();
    word_wr(3, 0, 2, 32'h1234_5678, 1);
    access(5, 3, 2, 4'b0111, 0);
    expect_hit("R13", 0);
    access(5, 3, 2, 4'hF, 0);
    expect_err("R7", 4, 0, 3);
    access(5, 3, 2, 4'hF, 0);
    expect_miss("R10", 1);
    access(24, 5, 0, 4'hF, 0);
    expect_hit("R10", 6);
  endtask

  // R4, R9, R11
  task automatic t_valid_mismatch();
    tag_wr(7, 4, 30, 0, 1);
    access(30, 7, 0, 4'b1110, 0);
    expect_hit("R13", 4);
    access(31, 7, 0, 4'b0001, 0);
    expect_err("R4", 1, 4, 7);
    check("R9", "err_addr value", g_eaddr, 263);
    access(30, 7, 0, 4'hF, 0);
    expect_miss("R10", 2);
  endtask

  // R5, R11
  task automatic t_tag_parity();
    tag_wr(8, 6, 40, 1, 0);
    access(40, 8, 0, 4'b1101, 0);
    expect_hit("R11", 6);
    access(40, 8, 0, 4'hF, 0);
    expect_err("R5", 2, 6, 8);
    access(40, 8, 0, 4'hF, 0);
    expect_miss("R10", 3);
  endtask

  // R6
  task automatic t_multi();
    tag_wr(10, 1, 50, 0, 0);
    tag_wr(10, 5, 50, 0, 0);
    access(50, 10, 0, 4'b1011, 0);
    expect_hit("R6", 1);
    access(50, 10, 0, 4'hF, 0);
    expect_err("R6", 3, 5, 10);
  endtask

  task automatic build11();
    tag_wr(11, 2, 60, 0, 0);
    tag_wr(11, 3, 60, 0, 0);
    tag_wr(11, 6, 61, 1, 0);
    tag_wr(11, 7, 62, 0, 1);
  endtask

  // R8
  task automatic t_priority();
    build11();
    access(60, 11, 0, 4'hF, 0);
    expect_err("R8", 1, 7, 11);
    build11();
    access(60, 11, 0, 4'b1110, 0);
    expect_err("R8", 2, 6, 11);
    build11();
    access(60, 11, 0, 4'b1100, 0);
    expect_err("R8", 3, 3, 11);
    build11();
    word_wr(11, 2, 0, 32'h0000_0001, 1);
    access(60, 11, 0, 4'b1000, 0);
    expect_err("R8", 4, 2, 11);
  endtask

  // R12
  task automatic t_flush();
    access(25, 5, 0, 4'hF, 1);
    check("R12", "flush code", g_code, 0);
    check("R12", "flush miss", g_miss, 0);
    access(25, 5, 0, 4'hF, 0);
    expect_miss("R12", 4);
    access(25, 5, 0, 4'hF, 0);
    expect_hit("R12", 4);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1;
    t_reset();
    t_fill_rr();
    t_word_parity();
    t_valid_mismatch();
    t_tag_parity();
    t_multi();
    t_priority();
    t_flush();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule